// File: doc/BRIEF.md
# Correlation Score Combiner

This block takes the eight per-stage match counts of a binary correlation array and turns them into final scores. Each stage count is weighted by the significance of the data bit its stage carries. The weighted counts are summed and a programmed offset is added. The result then passes through a delay line whose length is programmable. This lets a chain of devices line up their partial scores. In single-correlator operation a 13-bit partial score from an upstream device is added at the very end, which forms the cascade output.

In dual operation the array is split into two independent four-stage correlators. Each has its own offset. The upper half (stages 7..4) drives the low nine bits of the cascade output. The lower half (stages 3..0) drives the 9-bit auxiliary output. The cascade input is not used in this mode.

Top module: `corr_score_combine`

## Requirements
- R1: With `bit_sel` = 0 (1-bit data) and `dual` = 0, the pre-cascade score is the plain sum of all eight stage counts plus `off_a`, taken modulo 2^13.
- R2: `bit_sel` selects the group size G = 2^bit_sel (0: 1-bit, 1: 2-bit, 2: 4-bit, 3: 8-bit). Stage s carries data bit k = s mod G, and its count is multiplied by 2^k before summing. Stage s occupies bits 6s+5..6s of `stage_cnt`.
- R3: The single-mode score, the offset and the cascade sum wrap modulo 2^13 with no saturation.
- R4: A result reaches the outputs 2 + `dly_sel` clock cycles after its stage counts are presented. `dly_sel` = 0 adds nothing, and each step adds one register, up to 15.
- R5: In single mode, `cas_out` equals the delayed score plus the `casc_in` value present in the cycle just before `cas_out` updates.
- R6: With `dual` = 1, `cas_out[8:0]` carries (weighted sum of stages 7..4 + `off_a[8:0]`) mod 2^9, and `cas_out[12:9]` is zero. `aux_out` carries (weighted sum of stages 3..0 + `off_b`) mod 2^9. Within each half, the stage at position p carries bit p mod G.
- R7: In dual mode `casc_in` has no effect on the outputs. A `bit_sel` of 3 is treated as 2 (4-bit groups).
- R8: In single mode `aux_out` is zero and `off_b` has no effect.
- R9: While `rst_n` is low, `cas_out` and `aux_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_cnt | input | 48 | Eight 6-bit stage match counts, stage 0 in the low bits |
| bit_sel | input | 2 | Data precision: 0=1, 1=2, 2=4, 3=8 bits |
| dual | input | 1 | 1 = two independent correlators |
| off_a | input | 13 | Offset of the first (or only) correlator |
| off_b | input | 9 | Offset of the second correlator |
| dly_sel | input | 4 | Extra delay, in cycles, before the cascade adder |
| casc_in | input | 13 | Partial score from the upstream device |
| cas_out | output | 13 | Cascade score, or the first dual score in bits 8..0 |
| aux_out | output | 9 | Second dual score, zero in single mode |

## Verification
The bench builds the block with its default parameters: eight stages of 32 taps, a 13-bit cascade path and a delay line of fifteen registers. With these values the full set of data-precision modes can be exercised, and the 8-bit mode with all counts at 32 plus a large offset and cascade input reaches the modulo-2^13 wrap. Every delay setting from zero to the maximum is in range of a short run, and in dual mode the 4-bit grouping reaches the 9-bit wrap of each half.

// File: rtl/corr_score_combine_pkg.sv
package corr_score_combine_pkg;

  parameter int NSTG   = 8;
  parameter int TAPS   = 32;
  parameter int CNT_W  = $clog2(TAPS + 1);
  parameter int FULL_W = 13;
  parameter int HALF_W = 9;
  parameter int DLY_W  = 4;
  parameter int MAX_DLY = (1 << DLY_W) - 1;
  localparam int HALF_STG = NSTG / 2;

  typedef struct packed {
    logic              dual;
    logic [FULL_W-1:0] a;
    logic [HALF_W-1:0] b;
  } score_t;

  localparam int SCORE_W = $bits(score_t);

  // Weighted sum of stages first..first+n-1; the stage at position p
  // inside the range is shifted by p mod 2^glog.
  function automatic logic [FULL_W-1:0] weigh_range(
      input logic [NSTG*CNT_W-1:0] cnt,
      input int                    first,
      input int                    n,
      input logic [1:0]            glog);
    logic [FULL_W-1:0] acc;
    int                mask;
    mask = (1 << glog) - 1;
    acc  = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (s >= first && s < first + n)
        acc = acc + (FULL_W'(cnt[s*CNT_W +: CNT_W]) << ((s - first) & mask));
    end
    return acc;
  endfunction

  function automatic logic [1:0] dual_glog(input logic [1:0] sel);
    return (sel == 2'd3) ? 2'd2 : sel;
  endfunction

endpackage

// File: rtl/cs_weigh.sv
module cs_weigh
  import corr_score_combine_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSTG*CNT_W-1:0]   stage_cnt,
  input  logic [1:0]              bit_sel,
  input  logic                    dual,
  input  logic [FULL_W-1:0]       off_a,
  input  logic [HALF_W-1:0]       off_b,
  output score_t                  score_q
);

  score_t            score_d;
  logic [FULL_W-1:0] sum_all;
  logic [FULL_W-1:0] sum_hi;
  logic [FULL_W-1:0] sum_lo;
  logic [1:0]        glog_d;

  always_comb begin
    glog_d  = dual_glog(bit_sel);
    sum_all = weigh_range(stage_cnt, 0, NSTG, bit_sel);
    sum_hi  = weigh_range(stage_cnt, HALF_STG, HALF_STG, glog_d);
    sum_lo  = weigh_range(stage_cnt, 0, HALF_STG, glog_d);
  end

  always_comb begin
    score_d.dual = dual;
    if (dual) begin
      score_d.a = FULL_W'(HALF_W'(sum_hi[HALF_W-1:0] + off_a[HALF_W-1:0]));
      score_d.b = HALF_W'(sum_lo[HALF_W-1:0] + off_b);
    end else begin
      score_d.a = sum_all + off_a;
      score_d.b = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) score_q <= '0;
    else        score_q <= score_d;
  end

endmodule

// File: rtl/cs_delay.sv
module cs_delay #(
  parameter int W     = 23,
  parameter int DEPTH = 15,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     tap
);

  logic [W-1:0] chain [DEPTH+1];

  assign chain[0] = din;

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= '0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_comb begin
    tap = din;
    for (int i = 1; i <= DEPTH; i++)
      if (int'(sel) == i) tap = chain[i];
  end

endmodule

// File: rtl/cs_cascade.sv
module cs_cascade
  import corr_score_combine_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  score_t            tap,
  input  logic [FULL_W-1:0] casc_in,
  output logic [FULL_W-1:0] cas_out,
  output logic [HALF_W-1:0] aux_out
);

  logic [FULL_W-1:0] cas_d;
  logic [HALF_W-1:0] aux_d;

  always_comb begin
    if (tap.dual) begin
      cas_d = FULL_W'(tap.a[HALF_W-1:0]);
      aux_d = tap.b;
    end else begin
      cas_d = tap.a + casc_in;
      aux_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_out <= '0;
      aux_out <= '0;
    end else begin
      cas_out <= cas_d;
      aux_out <= aux_d;
    end
  end

endmodule

// File: rtl/corr_score_combine.sv
module corr_score_combine
  import corr_score_combine_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSTG*CNT_W-1:0] stage_cnt,
  input  logic [1:0]            bit_sel,
  input  logic                  dual,
  input  logic [FULL_W-1:0]     off_a,
  input  logic [HALF_W-1:0]     off_b,
  input  logic [DLY_W-1:0]      dly_sel,
  input  logic [FULL_W-1:0]     casc_in,
  output logic [FULL_W-1:0]     cas_out,
  output logic [HALF_W-1:0]     aux_out
);

  // Named internal events, observed by the bound checker.
  score_t             s1_score;
  score_t             tap_score;
  logic [SCORE_W-1:0] tap_flat;

  cs_weigh u_weigh (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage_cnt (stage_cnt),
    .bit_sel   (bit_sel),
    .dual      (dual),
    .off_a     (off_a),
    .off_b     (off_b),
    .score_q   (s1_score)
  );

  cs_delay #(
    .W     (SCORE_W),
    .DEPTH (MAX_DLY),
    .SEL_W (DLY_W)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (dly_sel),
    .din   (s1_score),
    .tap   (tap_flat)
  );

  assign tap_score = score_t'(tap_flat);

  cs_cascade u_casc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tap     (tap_score),
    .casc_in (casc_in),
    .cas_out (cas_out),
    .aux_out (aux_out)
  );

endmodule

// File: rtl/corr_score_combine_chk.sv
module corr_score_combine_chk
  import corr_score_combine_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [DLY_W-1:0]   dly_sel,
  input logic [FULL_W-1:0]  casc_in,
  input logic [FULL_W-1:0]  cas_out,
  input logic [HALF_W-1:0]  aux_out,
  input score_t             s1_score,
  input score_t             tap_score
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  logic              tap_dual;
  logic [FULL_W-1:0] tap_a;
  logic [HALF_W-1:0] tap_b;
  assign tap_dual = tap_score.dual;
  assign tap_a    = tap_score.a;
  assign tap_b    = tap_score.b;

  // R4: a one-step delay hands the stage-1 score on one cycle later
  p_delay_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && dly_sel == DLY_W'(1) && $past(dly_sel) == DLY_W'(1))
      |-> tap_score == $past(s1_score));

  // R5: single-mode output is the delayed score plus the cascade input
  p_cascade_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(tap_dual))
      |-> cas_out == FULL_W'($past(tap_a) + $past(casc_in)));

  // R6: dual-mode output keeps its upper bits clear
  p_dual_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(tap_dual)) |-> cas_out[FULL_W-1:HALF_W] == '0);

  // R7: dual-mode scores pass without the cascade input
  p_dual_no_casc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(tap_dual))
      |-> (cas_out[HALF_W-1:0] == $past(tap_a[HALF_W-1:0]) && aux_out == $past(tap_b)));

  // R8: auxiliary output stays zero in single mode
  p_single_aux_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(tap_dual)) |-> aux_out == '0);

  // R9: outputs are clear while reset is held
  always_comb begin
    if (!rst_n) begin
      p_reset_zero_r9: assert (cas_out == '0 && aux_out == '0);
    end
  end

endmodule

bind corr_score_combine corr_score_combine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dly_sel   (dly_sel),
  .casc_in   (casc_in),
  .cas_out   (cas_out),
  .aux_out   (aux_out),
  .s1_score  (s1_score),
  .tap_score (tap_score)
);

// File: tb/test_corr_score_combine.sv
`timescale 1ns/1ps
module test_corr_score_combine;
  import corr_score_combine_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NSTG*CNT_W-1:0] stage_cnt = '0;
  logic [1:0]            bit_sel = '0;
  logic                  dual = 1'b0;
  logic [FULL_W-1:0]     off_a = '0;
  logic [HALF_W-1:0]     off_b = '0;
  logic [DLY_W-1:0]      dly_sel = '0;
  logic [FULL_W-1:0]     casc_in = '0;
  logic [FULL_W-1:0]     cas_out;
  logic [HALF_W-1:0]     aux_out;

  always #2 clk = ~clk;

  corr_score_combine i_corr_score_combine (
    .clk(clk), .rst_n(rst_n), .stage_cnt(stage_cnt), .bit_sel(bit_sel),
    .dual(dual), .off_a(off_a), .off_b(off_b), .dly_sel(dly_sel),
    .casc_in(casc_in), .cas_out(cas_out), .aux_out(aux_out)
  );

  typedef struct {
    int                due;
    logic [FULL_W-1:0] a;
    logic [HALF_W-1:0] b;
    bit                dl;
    string             req;
  } exp_t;

  exp_t              sb[$];
  logic [FULL_W-1:0] casc_hist [0:8191];
  int                cyc = 0;
  int                total = 0;
  int                bad = 0;
  bit                done = 0;
  int                cnt_v [NSTG];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Independent model: multiply by a power of two chosen from the lane index.
  function automatic int model_sum(int first, int n, int grp);
    int acc = 0;
    for (int p = 0; p < n; p++) acc += cnt_v[first + p] * (1 << (p % grp));
    return acc;
  endfunction

  task automatic step(bit push, string req);
    for (int s = 0; s < NSTG; s++) stage_cnt[s*CNT_W +: CNT_W] = CNT_W'(cnt_v[s]);
    casc_hist[cyc] = casc_in;
    if (push) begin
      exp_t e;
      e.due = cyc + 2 + int'(dly_sel);
      e.dl  = dual;
      e.req = req;
      if (dual) begin
        int g = (bit_sel == 2'd3) ? 4 : (1 << bit_sel);
        e.a = FULL_W'((model_sum(4, 4, g) + int'(off_a[HALF_W-1:0])) % 512);
        e.b = HALF_W'((model_sum(0, 4, g) + int'(off_b)) % 512);
      end else begin
        e.a = FULL_W'((model_sum(0, NSTG, 1 << bit_sel) + int'(off_a)) % 8192);
        e.b = '0;
      end
      sb.push_back(e);
    end
    @(negedge clk);
  endtask

  // Monitor: pop the item that is due and compare it with the outputs.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      int   exp_cas;
      e = sb.pop_front();
      if (e.dl) exp_cas = int'(e.a[HALF_W-1:0]);
      else      exp_cas = (int'(e.a) + int'(casc_hist[cyc-1])) % 8192;
      check({e.req, " cas_out"}, int'(cas_out), exp_cas);
      check({e.req, " aux_out"}, int'(aux_out), int'(e.b));
    end
  end

  // kind 0: random counts, 1: all counts at maximum
  task automatic segment(logic [1:0] bs, bit dm, int dly, int n, int kind, string req);
    bit_sel = bs; dual = dm; dly_sel = DLY_W'(dly);
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < NSTG; s++)
        cnt_v[s] = (kind == 1) ? TAPS : int'($urandom_range(TAPS, 0));
      if (kind != 1) casc_in = FULL_W'($urandom_range(8191, 0));
      step(1, req);
    end
    for (int s = 0; s < NSTG; s++) cnt_v[s] = 0;
    for (int i = 0; i < 20; i++) step(0, req);
  endtask

  initial begin
    for (int s = 0; s < NSTG; s++) cnt_v[s] = 0;
    repeat (3) @(negedge clk);
    check("R9 cas_out in reset", int'(cas_out), 0);
    check("R9 aux_out in reset", int'(aux_out), 0);
    rst_n = 1'b1;
    step(0, "idle");
    step(0, "idle");

    off_a = 13'd37; off_b = 9'd200;
    segment(2'd0, 1'b0, 0, 12, 0, "R1 R4 R5 R8 1-bit d0");
    segment(2'd1, 1'b0, 3, 12, 0, "R2 R5 2-bit d3");
    segment(2'd2, 1'b0, 1, 12, 0, "R2 4-bit d1");
    segment(2'd3, 1'b0, 7, 12, 0, "R2 8-bit d7");
    segment(2'd0, 1'b0, 15, 12, 0, "R4 max delay");
    off_a = 13'h1FFF; casc_in = 13'h1F00;
    segment(2'd3, 1'b0, 2, 4, 1, "R3 wrap");
    off_a = 13'h1F5; off_b = 9'h1A0;
    segment(2'd0, 1'b1, 2, 12, 0, "R6 R7 dual 1-bit");
    segment(2'd2, 1'b1, 0, 12, 0, "R6 R7 dual 4-bit");
    segment(2'd3, 1'b1, 5, 12, 0, "R7 dual clamp of 8-bit");
    segment(2'd1, 1'b0, 4, 12, 0, "R8 single aux with off_b");

    check("R4 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule